// File: doc/BRIEF.md
# Dual-Source Interrupt Down-Counter

This block counts events down from a programmable 8-bit start value and raises an interrupt request when the count reaches zero. The counting events come from one of two sources. The first is a CPU-cycle prescaler that gives one counter event for every four CPU clock enables. The second is a qualifying rising edge on video address line A12: a high sample counts only after a long enough run of low samples. The source is chosen by software.

The CPU drives four decoded write strobes that share one data byte:
- a strobe that sets the reload value;
- a strobe that selects the source and arms a reload-plus-one load;
- a strobe that disarms the interrupt and acknowledges it;
- a strobe that arms the interrupt.

The interrupt does not rise in the cycle that the count reaches zero. It waits a number of CPU clock enables that depends on the source: 1 for the prescaler, 3 for A12. The output then stays high until software acknowledges it.

The block runs on one fast system clock. `cpu_ce` and `vid_ce` are single-cycle enables that mark CPU and video clock steps.

Top module: `dual_src_irq_counter`

## Requirements
- R1: After synchronous reset, `irq` is low and remains low. Reset also clears the counter, the reload value, the enable, the pending-reload flag, the prescaler, the A12 low-time count and the delay line. The source after reset is A12 mode.
- R2: A `wr_mode` strobe selects the counting source from `wr_data[0]` (1 = CPU-cycle prescaler, 0 = A12 edges) and sets a pending-reload flag.
- R3: On a counter event with the pending-reload flag set, the counter loads the reload value plus one (modulo 256), the prescaler clears and the flag clears.
- R4: On a counter event with no pending reload and the counter at zero, the counter loads the reload value, the prescaler clears, and no interrupt is scheduled. With reload value 0, the counter therefore stays at zero and never interrupts again.
- R5: On any other counter event the counter decrements. Reaching zero schedules an interrupt only if the enable is set at that time.
- R6: In CPU mode, a 2-bit prescaler advances on each `cpu_ce` and gives a counter event when it wraps to zero. `irq` rises on the first `cpu_ce` after the scheduling event. For reload value N (mode and enable written with `cpu_ce` low after reset), `irq` is first high after the 4(N+2)+1-th `cpu_ce`.
- R7: In A12 mode, `irq` rises on the third `cpu_ce` after the clock enable that scheduled it.
- R8: A sample with `vid_ce` and `vid_a12` high gives a counter event only when more than 8 consecutive `vid_ce` samples with A12 low came before it. Any high sample clears the low-time count, and cycles with `vid_ce` low do not count.
- R9: The A12 low-time count saturates, so an arbitrarily long low period still qualifies the next high sample.
- R10: `wr_disable` clears the enable, drives `irq` low in the next cycle and cancels any interrupt still in the delay line.
- R11: `wr_enable` sets the enable and leaves an asserted `irq` high.
- R12: Once high, `irq` stays high until a `wr_disable` strobe.
- R13: The source that is not selected does not clock the counter. A12 edges have no effect in CPU mode, and in A12 mode `cpu_ce` only advances the delay line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ce | input | 1 | CPU clock enable, one cycle per CPU step |
| vid_ce | input | 1 | Video clock enable, one cycle per A12 sample |
| vid_a12 | input | 1 | Level of video address line A12, sampled when `vid_ce` is high |
| wr_reload | input | 1 | Write strobe: reload value <= `wr_data` |
| wr_mode | input | 1 | Write strobe: source <= `wr_data[0]`, arm reload-plus-one |
| wr_disable | input | 1 | Write strobe: clear enable, acknowledge interrupt |
| wr_enable | input | 1 | Write strobe: set enable |
| wr_data | input | 8 | CPU write data |
| irq | output | 1 | Active-high interrupt request |

## Verification
Directed runs in CPU mode with reload values 0, 1 and 5 measure the first and second interrupt cycles. These runs tell the reload-plus-one load apart from the plain reload at zero, and they expose an off-by-one error in the prescaler or the delay. The same reload values in A12 mode use lines of nine low samples and one high sample. These runs tell the three-step delay apart from the one-step delay. A12 patterns with eight low samples, with gaps in `vid_ce`, and with a forty-sample low run separate the strict threshold from a lenient threshold and a saturating count from a wrapping one. Cross-source patterns show that the unselected source is ignored. A long constrained-random stretch then mixes writes, enables and A12 runs against a reference model to catch interactions between strobes and events in the same cycle.

// File: rtl/dsirq_pkg.sv
package dsirq_pkg;

    localparam int CNT_W_DEF   = 8;
    localparam int PRE_W_DEF   = 2;
    localparam int LOW_MIN_DEF = 8;
    localparam int DLY_CPU_DEF = 1;
    localparam int DLY_A12_DEF = 3;

    typedef enum logic {
        SRC_A12 = 1'b0,
        SRC_CPU = 1'b1
    } src_e;

    typedef struct packed {
        logic set_reload;
        logic set_mode;
        logic ack;
        logic arm;
    } wr_stb_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dsirq_prescaler.sv
module dsirq_prescaler #(
    parameter int PRE_W = dsirq_pkg::PRE_W_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic cpu_ce,
    input  logic active,
    input  logic clear,
    output logic tick
);
    logic [PRE_W-1:0] pre_q;

    // A tick marks the step where the prescaler wraps back to zero
    assign tick = active && cpu_ce && (pre_q == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (clear) begin
            pre_q <= '0;
        end else if (active && cpu_ce) begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    assert_prescaler_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        tick |=> (pre_q == '0));

    assert_prescaler_idle_R13: assert property (@(posedge clk) disable iff (rst)
        (!active && !clear) |=> $stable(pre_q));

endmodule

// File: rtl/dsirq_a12_filter.sv
module dsirq_a12_filter #(
    parameter int LOW_MIN = dsirq_pkg::LOW_MIN_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic vid_ce,
    input  logic vid_a12,
    output logic edge_ok
);
    localparam int LOW_W = $clog2(LOW_MIN + 2);
    localparam logic [LOW_W-1:0] LOW_SAT = '1;

    logic [LOW_W-1:0] low_q;

    assign edge_ok = vid_ce && vid_a12 && (low_q > LOW_W'(LOW_MIN));

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q <= '0;
        end else if (vid_ce) begin
            if (vid_a12) begin
                low_q <= '0;
            end else if (low_q != LOW_SAT) begin
                low_q <= low_q + LOW_W'(1);
            end
        end
    end

    assert_low_saturates_R9: assert property (@(posedge clk) disable iff (rst)
        (vid_ce && !vid_a12 && low_q == LOW_SAT) |=> (low_q == LOW_SAT));

    assert_high_clears_low_R8: assert property (@(posedge clk) disable iff (rst)
        (vid_ce && vid_a12) |=> (low_q == '0));

    assert_gap_holds_low_R8: assert property (@(posedge clk) disable iff (rst)
        !vid_ce |=> $stable(low_q));

endmodule

// File: rtl/dsirq_counter.sv
module dsirq_counter
    import dsirq_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_clk,
    input  logic             set_reload,
    input  logic             set_mode,
    input  logic [CNT_W-1:0] data,
    output src_e             src,
    output logic             load,
    output logic             zero_hit
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;
    logic             pend_q;
    src_e             src_q;
    logic             at_zero;
    logic [CNT_W-1:0] reload_p1;

    assign at_zero   = (cnt_q == '0);
    assign reload_p1 = reload_q + CNT_W'(1);
    assign load      = cnt_clk && (pend_q || at_zero);
    assign zero_hit  = cnt_clk && !pend_q && (cnt_q == CNT_W'(1));
    assign src       = src_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            reload_q <= '0;
            pend_q   <= 1'b0;
            src_q    <= SRC_A12;
        end else begin
            if (cnt_clk) begin
                if (pend_q) begin
                    cnt_q  <= reload_p1;
                    pend_q <= 1'b0;
                end else if (at_zero) begin
                    cnt_q <= reload_q;
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end
            if (set_reload) begin
                reload_q <= data;
            end
            if (set_mode) begin
                src_q  <= src_e'(data[0]);
                pend_q <= 1'b1;
            end
        end
    end

    assert_pending_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (pend_q && cnt_clk && !set_mode) |=> !pend_q);

    assert_mode_arms_R2: assert property (@(posedge clk) disable iff (rst)
        set_mode |=> pend_q);

    assert_zero_reloads_R4: assert property (@(posedge clk) disable iff (rst)
        (cnt_clk && !pend_q && at_zero) |=> (cnt_q == $past(reload_q)));

    assert_hold_without_event_R13: assert property (@(posedge clk) disable iff (rst)
        !cnt_clk |=> $stable(cnt_q));

endmodule

// File: rtl/dsirq_irq_delay.sv
module dsirq_irq_delay #(
    parameter int DLY_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_ce,
    input  logic             zero_hit,
    input  logic [DLY_W-1:0] sched_len,
    input  logic             arm,
    input  logic             ack,
    output logic             irq
);
    logic             en_q;
    logic             irq_q;
    logic [DLY_W-1:0] dly_q;
    logic             sched;

    assign sched = zero_hit && en_q;
    assign irq   = irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            irq_q <= 1'b0;
            dly_q <= '0;
        end else if (ack) begin
            en_q  <= 1'b0;
            irq_q <= 1'b0;
            dly_q <= '0;
        end else begin
            if (arm) begin
                en_q <= 1'b1;
            end
            if (sched) begin
                dly_q <= sched_len;
            end else if (cpu_ce && dly_q != '0) begin
                dly_q <= dly_q - DLY_W'(1);
                if (dly_q == DLY_W'(1)) begin
                    irq_q <= 1'b1;
                end
            end
        end
    end

    assert_rise_on_cpu_ce_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(cpu_ce));

    assert_ack_drops_irq_R10: assert property (@(posedge clk) disable iff (rst)
        ack |=> !irq_q);

    assert_irq_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !ack) |=> irq_q);

    assert_arm_keeps_irq_R11: assert property (@(posedge clk) disable iff (rst)
        (irq_q && arm && !ack) |=> irq_q);

endmodule

// File: rtl/dual_src_irq_counter.sv
module dual_src_irq_counter
    import dsirq_pkg::*;
#(
    parameter int CNT_W   = CNT_W_DEF,
    parameter int PRE_W   = PRE_W_DEF,
    parameter int LOW_MIN = LOW_MIN_DEF,
    parameter int DLY_CPU = DLY_CPU_DEF,
    parameter int DLY_A12 = DLY_A12_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_ce,
    input  logic             vid_ce,
    input  logic             vid_a12,
    input  logic             wr_reload,
    input  logic             wr_mode,
    input  logic             wr_disable,
    input  logic             wr_enable,
    input  logic [CNT_W-1:0] wr_data,
    output logic             irq
);
    localparam int DLY_W = $clog2(imax(DLY_CPU, DLY_A12) + 1);

    wr_stb_t          stb;
    src_e             src;
    logic             pre_tick;
    logic             a12_ok;
    logic             cnt_clk;
    logic             load;
    logic             zero_hit;
    logic [DLY_W-1:0] sched_len;

    assign stb = '{set_reload: wr_reload, set_mode: wr_mode,
                   ack: wr_disable, arm: wr_enable};

    dsirq_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .cpu_ce (cpu_ce),
        .active (src == SRC_CPU),
        .clear  (load),
        .tick   (pre_tick)
    );

    dsirq_a12_filter #(.LOW_MIN(LOW_MIN)) u_filt (
        .clk     (clk),
        .rst     (rst),
        .vid_ce  (vid_ce),
        .vid_a12 (vid_a12),
        .edge_ok (a12_ok)
    );

    // Only the selected source produces counter events
    assign cnt_clk   = pre_tick || (a12_ok && src == SRC_A12);
    assign sched_len = (src == SRC_CPU) ? DLY_W'(DLY_CPU) : DLY_W'(DLY_A12);

    dsirq_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .cnt_clk    (cnt_clk),
        .set_reload (stb.set_reload),
        .set_mode   (stb.set_mode),
        .data       (wr_data),
        .src        (src),
        .load       (load),
        .zero_hit   (zero_hit)
    );

    dsirq_irq_delay #(.DLY_W(DLY_W)) u_dly (
        .clk       (clk),
        .rst       (rst),
        .cpu_ce    (cpu_ce),
        .zero_hit  (zero_hit),
        .sched_len (sched_len),
        .arm       (stb.arm),
        .ack       (stb.ack),
        .irq       (irq)
    );

    assert_cpu_src_ignores_a12_R13: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_CPU && !cpu_ce) |-> !cnt_clk);

    assert_reset_irq_low_R1: assert property (@(posedge clk)
        rst |=> !irq);

endmodule

// File: tb/test_dual_src_irq_counter.sv
`timescale 1ns/1ps
module test_dual_src_irq_counter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_ce = 1'b0, vid_ce = 1'b0, vid_a12 = 1'b0;
    logic       wr_reload = 1'b0, wr_mode = 1'b0, wr_disable = 1'b0, wr_enable = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // reference state, derived from the requirements
    bit       m_src, m_pend, m_en, m_irq;
    bit [7:0] m_cnt, m_rel;
    bit [1:0] m_pre;
    int       m_low, m_dly;

    dual_src_irq_counter i_dual_src_irq_counter (
        .clk(clk), .rst(rst), .cpu_ce(cpu_ce), .vid_ce(vid_ce), .vid_a12(vid_a12),
        .wr_reload(wr_reload), .wr_mode(wr_mode), .wr_disable(wr_disable),
        .wr_enable(wr_enable), .wr_data(wr_data), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_src = 0; m_pend = 0; m_en = 0; m_irq = 0;
        m_cnt = 0; m_rel = 0; m_pre = 0; m_low = 0; m_dly = 0;
    endtask

    task automatic model_step(input bit c, input bit v, input bit a, input bit wr_r,
                              input bit wr_m, input bit wr_x, input bit wr_e,
                              input bit [7:0] d);
        bit tick, a12ok, cclk, hit, sched;
        int len;
        tick  = m_src && c && (m_pre == 2'd3);
        a12ok = !m_src && v && a && (m_low > 8);
        cclk  = tick || a12ok;
        len   = m_src ? 1 : 3;
        hit   = 0;
        if (v) m_low = a ? 0 : ((m_low < 15) ? m_low + 1 : 15);
        if (m_src && c) m_pre = m_pre + 2'd1;
        if (cclk) begin
            if (m_pend) begin
                m_cnt = m_rel + 8'd1; m_pend = 0; m_pre = 0;
            end else if (m_cnt == 0) begin
                m_cnt = m_rel; m_pre = 0;
            end else begin
                m_cnt = m_cnt - 8'd1;
                hit = (m_cnt == 0);
            end
        end
        sched = hit && m_en;
        if (wr_m) begin m_src = d[0]; m_pend = 1; end
        if (wr_r) m_rel = d;
        if (wr_x) begin
            m_en = 0; m_irq = 0; m_dly = 0;
        end else begin
            if (wr_e) m_en = 1;
            if (sched) m_dly = len;
            else if (c && m_dly != 0) begin
                if (m_dly == 1) m_irq = 1;
                m_dly--;
            end
        end
    endtask

    task automatic step(input bit c, input bit v, input bit a, input bit wr_r,
                        input bit wr_m, input bit wr_x, input bit wr_e, input bit [7:0] d);
        @(negedge clk);
        cpu_ce = c; vid_ce = v; vid_a12 = a;
        wr_reload = wr_r; wr_mode = wr_m; wr_disable = wr_x; wr_enable = wr_e; wr_data = d;
        model_step(c, v, a, wr_r, wr_m, wr_x, wr_e, d);
        @(posedge clk);
        #1;
        chk(irq == m_irq, "R12 irq vs model", irq, m_irq);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cpu_ce = 0; vid_ce = 0; vid_a12 = 0;
        wr_reload = 0; wr_mode = 0; wr_disable = 0; wr_enable = 0; wr_data = 0;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(irq == 1'b0, "R1 irq after reset", irq, 0);
    endtask

    task automatic setup(input bit [7:0] n, input bit mode, input bit arm);
        do_reset();
        step(0, 0, 0, 1, 0, 0, 0, n);
        step(0, 0, 0, 0, 1, 0, 0, {7'd0, mode});
        if (arm) step(0, 0, 0, 0, 0, 0, 1, 8'd0);
    endtask

    // A12 line: lows low samples then one high sample, cpu_ce every step
    task automatic a12_line(input int lows, inout int k, inout int first);
        for (int i = 0; i < lows + 1; i++) begin
            step(1, 1, (i == lows), 0, 0, 0, 0, 8'd0);
            k++;
            if (irq && first == 0) first = k;
        end
    endtask

    task automatic cpu_case(input int n);
        int first, second, k, limit;
        first = 0; second = 0; k = 0;
        setup(8'(n), 1'b1, 1'b1);
        limit = 4 * (n + 2) + 4 * (n + 1) + 24;
        while (k < limit) begin
            step(1, 0, 0, 0, 0, 0, 0, 8'd0);
            k++;
            if (irq && first == 0) begin
                first = k;
                step(0, 0, 0, 0, 0, 0, 1, 8'd0);
                chk(irq == 1'b1, "R11 enable keeps irq", irq, 1);
                step(0, 0, 0, 0, 0, 1, 0, 8'd0);
                chk(irq == 1'b0, "R10 disable drops irq", irq, 0);
                step(0, 0, 0, 0, 0, 0, 1, 8'd0);
            end else if (irq && first != 0 && second == 0) begin
                second = k;
            end
        end
        chk(first == 4 * (n + 2) + 1, "R2/R3/R6 first cpu-mode irq", first, 4 * (n + 2) + 1);
        if (n == 0)
            chk(second == 0, "R4 zero reload never refires", second, 0);
        else
            chk(second == first + 4 * (n + 1), "R4 second cpu-mode irq", second,
                first + 4 * (n + 1));
    endtask

    task automatic a12_case(input int n);
        int first, k;
        first = 0; k = 0;
        setup(8'(n), 1'b0, 1'b1);
        for (int j = 0; j < n + 4; j++) a12_line(9, k, first);
        chk(first == 10 * (n + 2) + 3, "R7 first a12-mode irq", first, 10 * (n + 2) + 3);
        chk(irq == 1'b1, "R12 irq held high", irq, 1);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int first, k;
        void'($urandom(32'd1234));

        // R1: idle after reset, cpu_ce toggling in default A12 mode
        do_reset();
        for (int i = 0; i < 40; i++) step(1, 0, 0, 0, 0, 0, 0, 8'd0);
        chk(irq == 1'b0, "R1 idle stays low", irq, 0);

        cpu_case(0);
        cpu_case(1);
        cpu_case(5);
        a12_case(0);
        a12_case(1);
        a12_case(5);

        // R5: counter reaches zero with enable clear
        setup(8'd1, 1'b1, 1'b0);
        for (int i = 0; i < 60; i++) step(1, 0, 0, 0, 0, 0, 0, 8'd0);
        chk(irq == 1'b0, "R5 no irq while disabled", irq, 0);

        // R8: eight-low lines and gapped lines never qualify
        setup(8'd0, 1'b0, 1'b1);
        first = 0; k = 0;
        for (int j = 0; j < 6; j++) a12_line(8, k, first);
        for (int j = 0; j < 4; j++) begin
            for (int i = 0; i < 8; i++) begin
                step(1, 1, 0, 0, 0, 0, 0, 8'd0);
                step(1, 0, 0, 0, 0, 0, 0, 8'd0);
            end
            step(1, 1, 1, 0, 0, 0, 0, 8'd0);
        end
        chk(irq == 1'b0, "R8 short lows ignored", irq, 0);
        first = 0; k = 0;
        for (int j = 0; j < 3; j++) a12_line(9, k, first);
        chk(first == 23, "R8 nine lows qualify", first, 23);

        // R9: long low run still qualifies
        setup(8'd0, 1'b0, 1'b1);
        first = 0; k = 0;
        a12_line(40, k, first);
        a12_line(9, k, first);
        a12_line(9, k, first);
        chk(first == 54, "R9 saturating low count", first, 54);

        // R10: disable inside the A12 delay window cancels it
        setup(8'd0, 1'b0, 1'b1);
        first = 0; k = 0;
        a12_line(9, k, first);
        a12_line(9, k, first);
        step(1, 1, 0, 0, 0, 1, 0, 8'd0);
        for (int i = 0; i < 10; i++) step(1, 1, 0, 0, 0, 0, 0, 8'd0);
        chk(irq == 1'b0, "R10 delay cancelled", irq, 0);

        // R13: CPU mode with no cpu_ce ignores valid A12 lines
        setup(8'd0, 1'b1, 1'b1);
        for (int j = 0; j < 8; j++) begin
            for (int i = 0; i < 9; i++) step(0, 1, 0, 0, 0, 0, 0, 8'd0);
            step(0, 1, 1, 0, 0, 0, 0, 8'd0);
        end
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, 0, 8'd0);
        chk(irq == 1'b0, "R13 a12 ignored in cpu mode", irq, 0);
        // R13: A12 mode ignores cpu_ce as a counter source
        setup(8'd0, 1'b0, 1'b1);
        for (int i = 0; i < 80; i++) step(1, 0, 0, 0, 0, 0, 0, 8'd0);
        chk(irq == 1'b0, "R13 cpu_ce ignored in a12 mode", irq, 0);

        // constrained random against the reference model
        do_reset();
        begin
            bit a = 0;
            for (int i = 0; i < 6000; i++) begin
                int r;
                bit wr_r, wr_m, wr_x, wr_e;
                r = int'($urandom_range(0, 99));
                wr_r = (r < 2); wr_m = (r >= 2 && r < 4);
                wr_x = (r >= 4 && r < 6); wr_e = (r >= 6 && r < 9);
                if ($urandom_range(0, 11) == 0) a = ~a;
                step($urandom_range(0, 1) == 1, $urandom_range(0, 3) != 0, a,
                     wr_r, wr_m, wr_x, wr_e, 8'($urandom_range(0, 7)));
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule